// File: doc/BRIEF.md
# Mesh Crossbar Router Node

This block is one routing node of a two-dimensional mesh on-chip network. It has five ports: the local tile and four neighbour links (north, south, east and west). Every write moves through the node as a single one-cycle unit. That unit carries a full 32-bit destination address, a 32-bit source address and a 32-bit data word in parallel. There is no header phase and no multi-cycle message, so a transaction can never hold a path half-used.

Each input has a small FIFO behind a valid/ready handshake. The node reads the mesh coordinates from the upper bits of the destination address and compares them with its own coordinates, which are set by parameters. Routing is dimension-ordered: the column is resolved first, then the row. Each output has its own crossbar multiplexer and its own round-robin arbiter. The outputs work independently, so up to five transactions can cross the node in the same cycle.

Top module: `mesh_xbar_node`

## Requirements
- R1: While reset is held and in the first cycle after it, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: Destination address bits [31:26] give the target row and bits [25:20] give the target column. A transaction leaves the node with its destination, source and data fields unchanged.
- R3: When the target column is greater than the node's column, the transaction leaves on output 3 (east). When it is smaller, the transaction leaves on output 4 (west). The row has no effect on this choice.
- R4: When the target column equals the node's column, the row decides. A greater row leaves on output 2 (south) and a smaller row on output 1 (north). When the row also matches, the transaction leaves on output 0 (local).
- R5: A transaction accepted at a clock edge (`in_valid` and `in_ready` both high) is presented at its output right after that edge. It leaves in the first edge at which its output has both `out_valid` and `out_ready` high.
- R6: When several inputs request the same output, that output's pointer starts at input 0 after reset. The grant goes to the first requesting input at or after the pointer, in ascending order with wrap-around. The pointer moves to the input just after the winner only when the grant is accepted. Otherwise it holds.
- R7: Each input FIFO holds 2 entries. When it is full, `in_ready` drops. No transaction is lost, and the stored entries drain in arrival order once the output is ready.
- R8: With its output ready, an input can accept one transaction on every cycle without `in_ready` ever dropping.
- R9: Transactions from one input to one output leave in the order they were accepted.
- R10: Different outputs are served independently in the same cycle. A stalled output does not hold up traffic bound for another output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 5 | Per-input transaction valid (0 local, 1 north, 2 south, 3 east, 4 west) |
| in_ready | output | 5 | Per-input FIFO has room |
| in_dst | input | 5x32 | Per-input destination address |
| in_src | input | 5x32 | Per-input source address |
| in_data | input | 5x32 | Per-input data word |
| out_valid | output | 5 | Per-output transaction valid |
| out_ready | input | 5 | Per-output downstream can take a transaction |
| out_dst | output | 5x32 | Per-output destination address |
| out_src | output | 5x32 | Per-output source address |
| out_data | output | 5x32 | Per-output data word |

## Verification
There is exactly one register stage between an accepting rising edge and the output. Each check of an output is therefore made at the falling edge that follows the edge at which the input was accepted. Inputs are also driven at falling edges. Arbitration does not depend on `out_ready`, so a granted head can be checked before and after ready is raised. Each following winner is checked one falling edge later. For backpressure, `in_ready` is checked one falling edge after the edge that fills the second FIFO entry.

// File: rtl/mesh_node_pkg.sv
package mesh_node_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int ROW_W  = 6;
  localparam int COL_W  = 6;
  localparam int NPORT  = 5;
  localparam int IDX_W  = $clog2(NPORT);

  typedef enum logic [IDX_W-1:0] {
    P_LOCAL = 3'd0,
    P_NORTH = 3'd1,
    P_SOUTH = 3'd2,
    P_EAST  = 3'd3,
    P_WEST  = 3'd4
  } port_e;

  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [DATA_W-1:0] data;
  } flit_t;

  function automatic logic [ROW_W-1:0] dst_row(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: ROW_W];
  endfunction

  function automatic logic [COL_W-1:0] dst_col(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-ROW_W-1 -: COL_W];
  endfunction

  // Dimension order: column first, then row, else local.
  function automatic logic [IDX_W-1:0] route_port(input logic [ADDR_W-1:0] a,
                                                  input logic [ROW_W-1:0] my_row,
                                                  input logic [COL_W-1:0] my_col);
    logic [ROW_W-1:0] r;
    logic [COL_W-1:0] c;
    r = dst_row(a);
    c = dst_col(a);
    if (c > my_col)      return P_EAST;
    else if (c < my_col) return P_WEST;
    else if (r > my_row) return P_SOUTH;
    else if (r < my_row) return P_NORTH;
    else                 return P_LOCAL;
  endfunction

  function automatic logic [IDX_W-1:0] rr_next(input logic [IDX_W-1:0] i);
    return (int'(i) == NPORT-1) ? '0 : i + 1'b1;
  endfunction

  // First requester at or after ptr, with wrap-around.
  function automatic logic [IDX_W-1:0] rr_pick(input logic [NPORT-1:0] req,
                                               input logic [IDX_W-1:0] ptr);
    logic [IDX_W-1:0] pick;
    logic             found;
    pick  = ptr;
    found = 1'b0;
    for (int k = 0; k < NPORT; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NPORT;
      if (!found && req[idx]) begin
        pick  = IDX_W'(idx);
        found = 1'b1;
      end
    end
    return pick;
  endfunction
endpackage

// File: rtl/mesh_in_fifo.sv
module mesh_in_fifo
  import mesh_node_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  flit_t         din,
  output logic          full,
  input  logic          pop,
  output flit_t         dout,
  output logic          valid,
  output logic [CW-1:0] count
);
  flit_t         mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
  endfunction

  assign full  = (int'(count) == DEPTH);
  assign valid = (count != '0);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wrap_inc(wptr);
      if (pop)  rptr <= wrap_inc(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mesh_rr_arb.sv
module mesh_rr_arb
  import mesh_node_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  input  logic             accept,
  output logic [IDX_W-1:0] win,
  output logic             win_vld,
  output logic [IDX_W-1:0] ptr
);
  assign win_vld = |req;
  assign win     = rr_pick(req, ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (accept) ptr <= rr_next(win);
  end
endmodule

// File: rtl/mesh_xbar_node.sv
module mesh_xbar_node
  import mesh_node_pkg::*;
#(
  parameter logic [ROW_W-1:0] MY_ROW = '0,
  parameter logic [COL_W-1:0] MY_COL = '0,
  parameter int FIFO_DEPTH = 2,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              in_valid,
  output logic [NPORT-1:0]              in_ready,
  input  logic [NPORT-1:0][ADDR_W-1:0]  in_dst,
  input  logic [NPORT-1:0][ADDR_W-1:0]  in_src,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_data,
  output logic [NPORT-1:0]              out_valid,
  input  logic [NPORT-1:0]              out_ready,
  output logic [NPORT-1:0][ADDR_W-1:0]  out_dst,
  output logic [NPORT-1:0][ADDR_W-1:0]  out_src,
  output logic [NPORT-1:0][DATA_W-1:0]  out_data
);
  flit_t                    head     [NPORT];
  logic [NPORT-1:0]         head_vld;
  logic [NPORT-1:0]         fifo_full;
  logic [NPORT-1:0][CW-1:0] fifo_cnt;
  logic [NPORT-1:0]         pop;
  logic [NPORT-1:0][IDX_W-1:0] head_port;
  logic [NPORT-1:0][NPORT-1:0] req;      // req[out][in]
  logic [NPORT-1:0][IDX_W-1:0] win_idx;
  logic [NPORT-1:0]         win_vld;
  logic [NPORT-1:0]         take;
  logic [NPORT-1:0][IDX_W-1:0] rr_ptr;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    flit_t din;
    assign din         = '{dst: in_dst[i], src: in_src[i], data: in_data[i]};
    assign in_ready[i] = !fifo_full[i];

    mesh_in_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[i] && in_ready[i]),
      .din   (din),
      .full  (fifo_full[i]),
      .pop   (pop[i]),
      .dout  (head[i]),
      .valid (head_vld[i]),
      .count (fifo_cnt[i])
    );

    assign head_port[i] = route_port(head[i].dst, MY_ROW, MY_COL);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    for (genvar i = 0; i < NPORT; i++) begin : g_req
      assign req[o][i] = head_vld[i] && (int'(head_port[i]) == o);
    end

    mesh_rr_arb u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req[o]),
      .accept  (take[o]),
      .win     (win_idx[o]),
      .win_vld (win_vld[o]),
      .ptr     (rr_ptr[o])
    );

    assign out_valid[o] = win_vld[o];
    assign take[o]      = win_vld[o] && out_ready[o];
    assign out_dst[o]   = head[win_idx[o]].dst;
    assign out_src[o]   = head[win_idx[o]].src;
    assign out_data[o]  = head[win_idx[o]].data;
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++) begin
      if (take[o]) pop[win_idx[o]] = 1'b1;
    end
  end
endmodule

// File: rtl/mesh_xbar_node_chk.sv
module mesh_xbar_node_chk
  import mesh_node_pkg::*;
#(
  parameter logic [ROW_W-1:0] MY_ROW = '0,
  parameter logic [COL_W-1:0] MY_COL = '0,
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NPORT-1:0]              out_valid,
  input logic [NPORT-1:0][ADDR_W-1:0]  out_dst,
  input logic [NPORT-1:0]              take,
  input logic [NPORT-1:0][IDX_W-1:0]   win_idx,
  input logic [NPORT-1:0][IDX_W-1:0]   rr_ptr,
  input logic [NPORT-1:0][CW-1:0]      fifo_cnt,
  input logic [NPORT-1:0]              pop
);
  a_r3_east_route: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[P_EAST] |-> dst_col(out_dst[P_EAST]) > MY_COL);
  a_r3_west_route: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[P_WEST] |-> dst_col(out_dst[P_WEST]) < MY_COL);
  a_r4_south_route: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[P_SOUTH] |-> (dst_col(out_dst[P_SOUTH]) == MY_COL) && (dst_row(out_dst[P_SOUTH]) > MY_ROW));
  a_r4_north_route: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[P_NORTH] |-> (dst_col(out_dst[P_NORTH]) == MY_COL) && (dst_row(out_dst[P_NORTH]) < MY_ROW));
  a_r4_local_route: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[P_LOCAL] |-> (dst_col(out_dst[P_LOCAL]) == MY_COL) && (dst_row(out_dst[P_LOCAL]) == MY_ROW));

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    a_r6_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      take[o] |=> rr_ptr[o] == rr_next($past(win_idx[o])));
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !take[o] |=> $stable(rr_ptr[o]));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fifo_cnt[i]) <= DEPTH);
    a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop[i] |-> fifo_cnt[i] != '0);
  end
endmodule

bind mesh_xbar_node mesh_xbar_node_chk #(
  .MY_ROW (MY_ROW),
  .MY_COL (MY_COL),
  .DEPTH  (FIFO_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_dst   (out_dst),
  .take      (take),
  .win_idx   (win_idx),
  .rr_ptr    (rr_ptr),
  .fifo_cnt  (fifo_cnt),
  .pop       (pop)
);

// File: tb/mesh_xbar_node_test.sv
`timescale 1ns/1ps
module mesh_xbar_node_test;
  import mesh_node_pkg::*;

  localparam logic [5:0] ROW = 6'd3;
  localparam logic [5:0] COL = 6'd5;

  logic clk = 1'b0;
  logic rst_n;
  logic [NPORT-1:0]             in_valid, in_ready, out_valid, out_ready;
  logic [NPORT-1:0][ADDR_W-1:0] in_dst, in_src, out_dst, out_src;
  logic [NPORT-1:0][DATA_W-1:0] in_data, out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mesh_xbar_node #(.MY_ROW(ROW), .MY_COL(COL), .FIFO_DEPTH(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src(in_src), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_dst(out_dst), .out_src(out_src), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_dst(input int r, input int c, input int off);
    return {6'(r), 6'(c), 20'(off)};
  endfunction

  task automatic do_reset(input logic [NPORT-1:0] rdy);
    rst_n     = 1'b0;
    in_valid  = '0;
    in_dst    = '0;
    in_src    = '0;
    in_data   = '0;
    out_ready = rdy;
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1 out_valid in reset", 32'(out_valid), 0);
    chk(in_ready == '1, "R1 in_ready in reset", 32'(in_ready), 32'h1f);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0 && in_ready == '1, "R1 after reset",
        {16'(out_valid), 16'(in_ready)}, 32'h0000_001f);
  endtask

  task automatic drive(input int p, input logic [31:0] d, input logic [31:0] s, input logic [31:0] x);
    in_valid[p] = 1'b1;
    in_dst[p]   = d;
    in_src[p]   = s;
    in_data[p]  = x;
  endtask

  // R2 R3 R4 R5: one transaction, check the port it leaves on
  task automatic route_case(input int sp, input int r, input int c, input int ep, input string req);
    logic [31:0] d, s, x;
    d = mk_dst(r, c, 20'h1234 + sp);
    s = 32'h5000_0000 + 32'(sp);
    x = 32'hD000_0000 + 32'(r * 64 + c);
    drive(sp, d, s, x);
    @(negedge clk);
    in_valid = '0;
    chk(out_valid == NPORT'(1 << ep), {req, " output port"}, 32'(out_valid), 32'(1 << ep));
    chk(out_dst[ep] == d && out_src[ep] == s && out_data[ep] == x, "R2 fields intact", out_data[ep], x);
    @(negedge clk);
    chk(out_valid == '0, "R5 leaves after accept", 32'(out_valid), 0);
  endtask

  task automatic t_routing();
    do_reset('1);
    route_case(0, 1, 9, P_EAST,  "R3 east");
    route_case(1, 7, 2, P_WEST,  "R3 west");
    route_case(2, 7, 5, P_SOUTH, "R4 south");
    route_case(3, 0, 5, P_NORTH, "R4 north");
    route_case(4, 3, 5, P_LOCAL, "R4 local");
  endtask

  // R6: round robin on the local output
  task automatic t_round_robin();
    do_reset(5'b11110);
    drive(1, mk_dst(3, 5, 1), 0, 101);
    drive(3, mk_dst(3, 5, 3), 0, 103);
    @(negedge clk);
    in_valid = '0;
    chk(out_valid[0] && out_data[0] == 101, "R6 first winner from ptr 0", out_data[0], 101);
    @(negedge clk);
    chk(out_data[0] == 101, "R6 hold while not ready", out_data[0], 101);
    out_ready[0] = 1'b1;
    #1;
    chk(out_data[0] == 101, "R6 winner with ready", out_data[0], 101);
    @(negedge clk);
    chk(out_valid[0] && out_data[0] == 103, "R6 second winner", out_data[0], 103);
    @(negedge clk);
    chk(!out_valid[0], "R6 drained", 32'(out_valid[0]), 0);
    out_ready[0] = 1'b0;
    drive(0, mk_dst(3, 5, 0), 0, 100);
    drive(4, mk_dst(3, 5, 4), 0, 104);
    @(negedge clk);
    in_valid = '0;
    chk(out_data[0] == 104, "R6 ptr at 4 picks input 4 first", out_data[0], 104);
    out_ready[0] = 1'b1;
    @(negedge clk);
    chk(out_valid[0] && out_data[0] == 100, "R6 wrap to input 0", out_data[0], 100);
    @(negedge clk);
    chk(!out_valid[0], "R6 drained again", 32'(out_valid[0]), 0);
  endtask

  // R7 R9: two-entry FIFO, backpressure, nothing lost
  task automatic t_backpressure();
    do_reset(5'b11110);
    drive(2, mk_dst(3, 5, 0), 0, 32'hA);
    @(negedge clk);
    chk(in_ready[2], "R7 room after one", 32'(in_ready[2]), 1);
    drive(2, mk_dst(3, 5, 0), 0, 32'hB);
    @(negedge clk);
    chk(!in_ready[2], "R7 full after two", 32'(in_ready[2]), 0);
    drive(2, mk_dst(3, 5, 0), 0, 32'hC);
    @(negedge clk);
    chk(!in_ready[2] && out_data[0] == 32'hA, "R7 still full, head kept", out_data[0], 32'hA);
    out_ready[0] = 1'b1;
    @(negedge clk);
    chk(out_data[0] == 32'hB && in_ready[2], "R9 second in order", out_data[0], 32'hB);
    @(negedge clk);
    in_valid = '0;
    chk(out_valid[0] && out_data[0] == 32'hC, "R7 held item delivered", out_data[0], 32'hC);
    @(negedge clk);
    chk(!out_valid[0], "R7 drained", 32'(out_valid[0]), 0);
  endtask

  // R8 R9: one write per cycle at full rate
  task automatic t_full_rate();
    int stalls;
    stalls = 0;
    do_reset('1);
    for (int k = 0; k < 20; k++) begin
      if (!in_ready[0]) stalls++;
      drive(0, mk_dst(0, 9, k), 0, 32'(200 + k));
      @(negedge clk);
      chk(out_valid[3] && out_data[3] == 32'(200 + k), "R9 stream order", out_data[3], 32'(200 + k));
    end
    in_valid = '0;
    chk(stalls == 0, "R8 no stall at full rate", 32'(stalls), 0);
    @(negedge clk);
    chk(!out_valid[3], "R8 stream drained", 32'(out_valid[3]), 0);
  endtask

  // R10: outputs independent
  task automatic t_independent();
    do_reset(5'b10111);
    drive(1, mk_dst(0, 9, 0), 0, 32'h11);
    drive(2, mk_dst(0, 1, 0), 0, 32'h22);
    @(negedge clk);
    in_valid = '0;
    chk(out_valid[3] && out_data[3] == 32'h11, "R10 east held", out_data[3], 32'h11);
    chk(out_valid[4] && out_data[4] == 32'h22, "R10 west served", out_data[4], 32'h22);
    @(negedge clk);
    chk(!out_valid[4] && out_valid[3], "R10 west gone east stalled",
        32'(out_valid), 32'h08);
    out_ready[3] = 1'b1;
    @(negedge clk);
    chk(!out_valid[3], "R10 east released", 32'(out_valid[3]), 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_routing();
    t_round_robin();
    t_backpressure();
    t_full_rate();
    t_independent();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule